// File: doc/BRIEF.md
# Runtime-Programmable Multiply-Shift Gain Stage

This block applies a fractional gain to a stream of signed 16-bit samples. The gain is written as an integer coefficient divided by a power of two. Each accepted sample is multiplied by the coefficient into a full-width signed product, which cannot overflow. The product is then shifted right arithmetically by the programmed amount. The shifted value is clamped into the signed 16-bit output range, so it never wraps.

A host loads the coefficient and the shift amount through a small write port while samples keep flowing. Both values are taken together on a single write strobe, so no sample ever sees half of an update. The input sample is registered before the arithmetic. The block takes one sample every clock and returns each result a fixed two cycles later. The host chooses the coefficient and shift pair; for example, 3 with a shift of 1 gives a gain of exactly 1.5, and 73 with a shift of 9 gives about 0.1425.

Top module: `mulshift_scaler`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0, and the active setting is coefficient 1 with shift 0, so samples pass through at unity gain until the first write.
- R2: out_valid equals in_valid from exactly two clock cycles earlier. A new sample can be accepted on every cycle.
- R3: For a sample x with coefficient m and shift s, out_data is clamp(floor(x*m / 2^s)). The product x*m is formed exactly in signed two's complement at 32 bits. For example, (3,1) gives a gain of exactly 1.5, (73,9) gives about 0.1425 and (102,10) gives about 0.0996.
- R4: The right shift is arithmetic. A negative product with nonzero discarded bits rounds toward minus infinity (for example, -3 with a shift of 1 gives -2), and the sign of the shifted value matches the sign of the product.
- R5: A shifted value above 32767 yields 32767, and one below -32768 yields -32768. The output sign always matches the sign of the shifted value.
- R6: A shift amount of 0 (the shift field is 5 bits, values 0 to 31) outputs the clamped product with no division.
- R7: When cfg_wr is high at a clock edge, cfg_mult and cfg_shift are both captured at that edge. A sample accepted at the same edge still uses the previous pair, and every sample accepted at a later edge uses the new pair.
- R8: While cfg_wr is low, cfg_mult and cfg_shift are ignored, and the active pair keeps its value.
- R9: In a cycle where out_valid is 0, out_data holds the last value it produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Strobe that loads the coefficient and shift pair |
| cfg_mult | input | 16 | Signed integer coefficient |
| cfg_shift | input | 5 | Right-shift amount, 0 to 31 |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Result qualifier, two cycles after in_valid |
| out_data | output | 16 | Signed scaled and clamped result |

## Verification
Two events can land on the same clock edge: a configuration write and the acceptance of a sample. The bench provokes this by pulsing cfg_wr on the same cycle as a valid sample every time it moves to a new coefficient and shift pair. It expects that sample to be scaled by the old pair and the next sample by the new one. The sweep covers every shift amount from 0 to 31 against extreme and ordinary coefficients and samples, with idle gaps between samples. Expected results are computed with 64-bit arithmetic and a floor shift, then clamped.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

   localparam int unsigned DEF_DATA_W  = 16;
   localparam int unsigned DEF_COEF_W  = 16;
   localparam int unsigned DEF_SHIFT_W = 5;

   typedef enum logic [1:0] {
      CLAMP_NONE = 2'd0,
      CLAMP_HIGH = 2'd1,
      CLAMP_LOW  = 2'd2
   } clamp_kind_e;

endpackage

// File: rtl/mulshift_cfg.sv
module mulshift_cfg #(
   parameter int unsigned COEF_W      = mulshift_pkg::DEF_COEF_W,
   parameter int unsigned SHIFT_W     = mulshift_pkg::DEF_SHIFT_W,
   parameter int          RESET_MULT  = 1,
   parameter int unsigned RESET_SHIFT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic signed [COEF_W-1:0] mult_in,
   input  logic [SHIFT_W-1:0]       shift_in,
   output logic signed [COEF_W-1:0] mult_q,
   output logic [SHIFT_W-1:0]       shift_q
);

   localparam logic signed [COEF_W-1:0] MULT_RST  = COEF_W'(RESET_MULT);
   localparam logic [SHIFT_W-1:0]       SHIFT_RST = SHIFT_W'(RESET_SHIFT);

   if (RESET_SHIFT >= (2 ** SHIFT_W)) begin : g_bad_rst_shift
      $error("mulshift_cfg: RESET_SHIFT does not fit SHIFT_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mult_q  <= MULT_RST;
         shift_q <= SHIFT_RST;
      end else if (wr) begin
         mult_q  <= mult_in;
         shift_q <= shift_in;
      end
   end

   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_pair_load_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(wr) |-> (mult_q == $past(mult_in)) && (shift_q == $past(shift_in)));

   assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(wr) |-> $stable(mult_q) && $stable(shift_q));

endmodule

// File: rtl/mulshift_barrel.sv
module mulshift_barrel #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned SHIFT_W = mulshift_pkg::DEF_SHIFT_W
) (
   input  logic signed [WIDTH-1:0] din,
   input  logic [SHIFT_W-1:0]      amt,
   output logic signed [WIDTH-1:0] dout
);

   if ((2 ** SHIFT_W) > WIDTH) begin : g_bad_range
      $error("mulshift_barrel: shift range exceeds operand width");
   end

   logic signed [WIDTH-1:0] stg [SHIFT_W+1];

   assign stg[0] = din;

   for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
      localparam int unsigned STEP = 2 ** k;
      assign stg[k+1] = amt[k] ? (stg[k] >>> STEP) : stg[k];
   end

   assign dout = stg[SHIFT_W];

endmodule

// File: rtl/mulshift_clamp.sv
module mulshift_clamp #(
   parameter int unsigned IN_W  = 32,
   parameter int unsigned OUT_W = mulshift_pkg::DEF_DATA_W
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);

   import mulshift_pkg::*;

   localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   if (OUT_W < 2) begin : g_bad_out
      $error("mulshift_clamp: OUT_W must be at least 2");
   end

   if (IN_W <= OUT_W) begin : g_no_clamp
      assign dout = OUT_W'(din);
   end else begin : g_clamp
      localparam int unsigned TOP_W = IN_W - OUT_W + 1;
      logic [TOP_W-1:0] top_bits;
      clamp_kind_e      kind;

      assign top_bits = din[IN_W-1:OUT_W-1];

      always_comb begin
         if (top_bits == '0 || top_bits == '1) kind = CLAMP_NONE;
         else if (din[IN_W-1])                 kind = CLAMP_LOW;
         else                                  kind = CLAMP_HIGH;
      end

      always_comb begin
         unique case (kind)
            CLAMP_HIGH: dout = OUT_MAX;
            CLAMP_LOW:  dout = OUT_MIN;
            default:    dout = din[OUT_W-1:0];
         endcase
      end
   end

endmodule

// File: rtl/mulshift_scaler.sv
module mulshift_scaler #(
   parameter int unsigned DATA_W      = mulshift_pkg::DEF_DATA_W,
   parameter int unsigned COEF_W      = mulshift_pkg::DEF_COEF_W,
   parameter int unsigned SHIFT_W     = mulshift_pkg::DEF_SHIFT_W,
   parameter int          RESET_MULT  = 1,
   parameter int unsigned RESET_SHIFT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic signed [COEF_W-1:0] cfg_mult,
   input  logic [SHIFT_W-1:0]       cfg_shift,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);

   localparam int unsigned PROD_W = DATA_W + COEF_W;

   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("mulshift_scaler: DATA_W and COEF_W must be at least 2");
   end
   if ((2 ** SHIFT_W) > PROD_W) begin : g_bad_shift
      $error("mulshift_scaler: SHIFT_W allows shifts beyond the product width");
   end

   logic signed [COEF_W-1:0] act_mult;
   logic [SHIFT_W-1:0]       act_shift;

   mulshift_cfg #(
      .COEF_W     (COEF_W),
      .SHIFT_W    (SHIFT_W),
      .RESET_MULT (RESET_MULT),
      .RESET_SHIFT(RESET_SHIFT)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .mult_in (cfg_mult),
      .shift_in(cfg_shift),
      .mult_q  (act_mult),
      .shift_q (act_shift)
   );

   // Stage 1: sample register with the setting that was active at capture.
   logic                     s1_valid;
   logic signed [DATA_W-1:0] s1_data;
   logic signed [COEF_W-1:0] s1_mult;
   logic [SHIFT_W-1:0]       s1_shift;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_data  <= '0;
         s1_mult  <= '0;
         s1_shift <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_data  <= in_data;
            s1_mult  <= act_mult;
            s1_shift <= act_shift;
         end
      end
   end

   // Full-width product: sign-extend both operands to PROD_W.
   logic signed [PROD_W-1:0] data_ext;
   logic signed [PROD_W-1:0] mult_ext;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;
   logic signed [DATA_W-1:0] clamped;

   assign data_ext = {{(PROD_W-DATA_W){s1_data[DATA_W-1]}}, s1_data};
   assign mult_ext = {{(PROD_W-COEF_W){s1_mult[COEF_W-1]}}, s1_mult};
   assign prod     = data_ext * mult_ext;

   mulshift_barrel #(
      .WIDTH  (PROD_W),
      .SHIFT_W(SHIFT_W)
   ) u_barrel (
      .din (prod),
      .amt (s1_shift),
      .dout(shifted)
   );

   mulshift_clamp #(
      .IN_W (PROD_W),
      .OUT_W(DATA_W)
   ) u_clamp (
      .din (shifted),
      .dout(clamped)
   );

   // Stage 2: output register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_data <= clamped;
      end
   end

   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_stage1_valid_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      s1_valid == $past(in_valid));

   assert_stage2_valid_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      out_valid == $past(s1_valid));

   assert_shift_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prod < 0) == (shifted < 0));

   assert_clamp_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (shifted < 0) == (clamped < 0));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !out_valid |-> $stable(out_data));

endmodule

// File: tb/mulshift_scaler_bench.sv
`timescale 1ns/1ps
module mulshift_scaler_bench;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_wr = 1'b0;
   logic signed [15:0] cfg_mult = '0;
   logic [4:0]         cfg_shift = '0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               out_valid;
   logic signed [15:0] out_data;

   always #2 clk = ~clk;

   mulshift_scaler u_mulshift_scaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_mult (cfg_mult),
      .cfg_shift(cfg_shift),
      .in_valid (in_valid),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // Bench model state
   longint model_mult  = 1;
   int     model_shift = 0;
   bit     pv [2]  = '{1'b0, 1'b0};
   longint pd [2]  = '{0, 0};
   string  pt [2]  = '{"R2", "R2"};
   longint last_out = 0;

   function automatic longint clamp16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic string auto_tag(longint x, longint m, int s);
      longint p = x * m;
      longint q = p >>> s;
      if (q > 32767 || q < -32768) return "R5";
      if (s == 0) return "R6";
      if (p < 0 && (p & ((64'sd1 <<< s) - 1)) != 0) return "R4";
      return "R3";
   endfunction

   task automatic check_outputs();
      checks++;
      if (out_valid !== pv[1]) begin
         fails++;
         $display("FAIL R2: out_valid actual %0b expected %0b", out_valid, pv[1]);
      end
      if (pv[1]) begin
         checks++;
         if (longint'(out_data) != pd[1]) begin
            fails++;
            $display("FAIL %s: out_data actual %0d expected %0d", pt[1], out_data, pd[1]);
         end
         last_out = pd[1];
      end else begin
         checks++;
         if (longint'(out_data) != last_out) begin
            fails++;
            $display("FAIL R9: idle out_data actual %0d expected %0d", out_data, last_out);
         end
      end
   endtask

   // One cycle: check, then drive inputs for the next edge.
   task automatic step(input bit v, input longint x, input bit wr,
                       input longint m, input int s, input string tag);
      @(negedge clk);
      check_outputs();
      pv[1] = pv[0];
      pd[1] = pd[0];
      pt[1] = pt[0];
      pv[0] = v;
      if (v) begin
         pd[0] = clamp16((x * model_mult) >>> model_shift);
         pt[0] = (tag != "") ? tag : auto_tag(x, model_mult, model_shift);
      end
      in_valid  = v;
      in_data   = 16'(x);
      cfg_wr    = wr;
      cfg_mult  = 16'(m);
      cfg_shift = 5'(s);
      if (wr) begin
         model_mult  = m;
         model_shift = s;
      end
   endtask

   task automatic fixed_case(input longint m, input int s, input longint x, input longint expv);
      step(1'b0, 0, 1'b1, m, s, "");
      step(1'b1, x, 1'b0, 0, 0, "R3");
      step(1'b0, 0, 1'b0, 0, 0, "");
      step(1'b0, 0, 1'b0, 0, 0, "");
      @(negedge clk);
      checks++;
      if (longint'(out_data) != expv) begin
         fails++;
         $display("FAIL R3: gain %0d/2^%0d on %0d actual %0d expected %0d", m, s, x, out_data, expv);
      end
   endtask

   localparam int NX = 20;
   localparam int NM = 12;
   longint xs [NX] = '{0, 1, -1, 2, -2, 100, -100, 1000, -1000, 12345, -12345,
                       32767, -32768, -32767, 7, -7, 255, -256, 16384, -16385};
   longint ms [NM] = '{1, 0, -1, 3, 73, 102, 32767, -32768, -3, 1000, -255, 2};

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0 || out_data !== 16'sd0) begin
         fails++;
         $display("FAIL R1: reset outputs actual %0b/%0d expected 0/0", out_valid, out_data);
      end
      rst_n = 1'b1;
      // R1: unity gain before any write
      step(1'b1, 12345, 1'b0, 0, 0, "R1");
      step(1'b1, -32768, 1'b0, 0, 0, "R1");
      step(1'b1, 77, 1'b0, 0, 0, "R1");
      step(1'b0, 0, 1'b0, 0, 0, "");
      step(1'b0, 0, 1'b0, 0, 0, "");

      // R3: known gains
      fixed_case(3, 1, 1000, 1500);
      fixed_case(73, 9, 1000, 142);
      fixed_case(102, 10, 1000, 99);
      fixed_case(-3, 1, 1, -2);

      // Sweep; every setting change coincides with a sample (R7)
      for (int s = 0; s < 32; s++) begin
         for (int mi = 0; mi < NM; mi++) begin
            step(1'b1, xs[(s + mi) % NX], 1'b1, ms[mi], s, "R7");
            for (int xi = 0; xi < NX; xi++) begin
               step(1'b1, xs[xi], 1'b0, 0, 0, "");
               if ((xi % 7) == 6) step(1'b0, 0, 1'b0, 0, 0, "");
            end
         end
      end

      // R8: setting inputs wiggle without the strobe
      step(1'b1, 500, 1'b1, 5, 2, "R7");
      for (int i = 0; i < 16; i++) begin
         step(1'b1, 1000 - 137 * i, 1'b0, 999 - 61 * i, (i * 3) % 32, "R8");
      end
      step(1'b0, 0, 1'b0, 0, 0, "");
      step(1'b0, 0, 1'b0, 0, 0, "");
      step(1'b0, 0, 1'b0, 0, 0, "");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule